// File: doc/BRIEF.md
# Masked Pattern Match and Trigger Unit

This block watches a wide data bus, one sample per clock, and compares each valid sample against two programmable pattern sets. Each set has a value and a mask, and each is stored as a row of 32-bit words. The first set raises a trigger pulse. The second set raises a pattern-match pulse, and it works on its own, apart from the trigger. One type bit selects the vector that both sets compare. In value mode that vector is the sample itself. In toggle mode it is the set of bits that changed since the previous valid sample.

Each of the two events can also request a timestamp. Each request has its own enable bit. A plain register port with a write strobe, an address and a combinational read bus holds the pattern words and the control bits. The surrounding trace logic consumes the pulses and the timestamp requests.

Top module: `pm_trigger_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all four outputs are 0. After reset every register address reads 0.
- R2: The register port maps four banks of eight words. Addresses 0..7 hold the trigger values, 8..15 the trigger masks, 16..23 the pattern values and 24..31 the pattern masks. Word k of a bank covers data bits 32k+31 down to 32k. A written word reads back unchanged. It first affects the sample taken in the cycle after the write.
- R3: Address 32 is the control register. Bit 0 is the type (0 for value, 1 for toggle), bit 1 the pattern timestamp enable, bit 2 the trigger timestamp enable and bit 3 the trigger type. Its upper bits read 0. Any other address reads 0, and writes to it change no readable state.
- R4: Only bits whose mask bit is 1 are compared. A set whose mask is all zeros never produces an event.
- R5: In value mode a set hits when the sample equals the set's value on every masked bit.
- R6: In toggle mode the compared vector is the current valid sample XOR the previous valid sample. The first valid sample after reset never hits in toggle mode.
- R7: `trigPulse` and `matchPulse` are single-cycle pulses in the cycle after a valid sample that hits the trigger set or the pattern set, respectively. A sample with `dataValid` low produces no pulse and does not update the previous sample.
- R8: `matchTsReq` is high exactly when `matchPulse` is high and the pattern timestamp enable was 1 for that sample.
- R9: `trigTsReq` is high exactly when `trigPulse` is high and the trigger timestamp enable was 1 for that sample.
- R10: The trigger type bit is stored and read back, and it has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| dataIn | input | 256 | Observed data bus |
| dataValid | input | 1 | dataIn holds a sample this cycle |
| trigPulse | output | 1 | Trigger event pulse |
| matchPulse | output | 1 | Pattern-match event pulse |
| trigTsReq | output | 1 | Timestamp request for the trigger |
| matchTsReq | output | 1 | Timestamp request for the pattern match |

## Verification
The trigger and the pattern match can hit on the same sample. One such sample is built so that it satisfies both sets at once, with both timestamp enables set. All four outputs must then rise together in the following cycle. A register write can also land in the same cycle as a sample. In that case the bench model judges the sample against the configuration that held before the write, and the change applies only from the next sample.

// File: rtl/pm_trig_pkg.sv
package pm_trig_pkg;

  // Strobes and mode bits passed from the control to the datapath.
  typedef struct packed {
    logic sampleEn;
    logic toggleMode;
    logic patTsEn;
    logic trigTsEn;
  } ctrlStrobes_t;

  localparam int BANK_COUNT = 4;
  localparam int BANK_TRIG_VAL = 0;
  localparam int BANK_TRIG_MASK = 1;
  localparam int BANK_PAT_VAL = 2;
  localparam int BANK_PAT_MASK = 3;

  localparam int CTRL_BITS = 4;
  localparam int CB_TOGGLE = 0;
  localparam int CB_PAT_TS = 1;
  localparam int CB_TRIG_TS = 2;
  localparam int CB_TRIG_TYPE = 3;

endpackage

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_trig_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  logic              dataValid,
  output ctrlStrobes_t      strobes,
  output logic [DATA_W-1:0] trigValW,
  output logic [DATA_W-1:0] trigMaskW,
  output logic [DATA_W-1:0] patValW,
  output logic [DATA_W-1:0] patMaskW
);
  localparam int NUM_WORDS = DATA_W / WORD_W;
  localparam int CTRL_ADDR = BANK_COUNT * NUM_WORDS;

  logic [BANK_COUNT-1:0][NUM_WORDS-1:0][WORD_W-1:0] bank;
  logic [CTRL_BITS-1:0] ctrlReg;

  for (genvar b = 0; b < BANK_COUNT; b++) begin : g_bank
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
        if (rst) begin
          bank[b][w] <= '0;
        end else if (regWrEn && regAddr == ADDR_W'(b * NUM_WORDS + w)) begin
          bank[b][w] <= regWrData;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg <= '0;
    end else if (regWrEn && regAddr == ADDR_W'(CTRL_ADDR)) begin
      ctrlReg <= regWrData[CTRL_BITS-1:0];
    end
  end

  always_comb begin
    regRdData = '0;
    for (int b = 0; b < BANK_COUNT; b++) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (regAddr == ADDR_W'(b * NUM_WORDS + w)) regRdData = bank[b][w];
      end
    end
    if (regAddr == ADDR_W'(CTRL_ADDR)) regRdData = WORD_W'(ctrlReg);
  end

  assign trigValW  = bank[BANK_TRIG_VAL];
  assign trigMaskW = bank[BANK_TRIG_MASK];
  assign patValW   = bank[BANK_PAT_VAL];
  assign patMaskW  = bank[BANK_PAT_MASK];

  // The trigger type bit is held for readback only.
  always_comb begin
    strobes.sampleEn   = dataValid;
    strobes.toggleMode = ctrlReg[CB_TOGGLE];
    strobes.patTsEn    = ctrlReg[CB_PAT_TS];
    strobes.trigTsEn   = ctrlReg[CB_TRIG_TS];
  end

endmodule

// File: rtl/pm_datapath.sv
module pm_datapath
  import pm_trig_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] trigValW,
  input  logic [DATA_W-1:0] trigMaskW,
  input  logic [DATA_W-1:0] patValW,
  input  logic [DATA_W-1:0] patMaskW,
  output logic              trigPulse,
  output logic              matchPulse,
  output logic              trigTsReq,
  output logic              matchTsReq
);
  localparam int NUM_WORDS = DATA_W / WORD_W;

  logic [DATA_W-1:0] prevData;
  logic havePrev;
  logic [DATA_W-1:0] cmpVec;
  logic [NUM_WORDS-1:0] trigWordOk, trigWordUsed, patWordOk, patWordUsed;
  logic eligible, trigHit, patHit;

  assign cmpVec   = strobes.toggleMode ? (dataIn ^ prevData) : dataIn;
  assign eligible = strobes.sampleEn && (!strobes.toggleMode || havePrev);

  // Compare word by word, so each reduction stays one word wide.
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_cmp
    logic [WORD_W-1:0] vSlice, tv, tm, pv, pm;
    assign vSlice = cmpVec[w*WORD_W +: WORD_W];
    assign tv = trigValW[w*WORD_W +: WORD_W];
    assign tm = trigMaskW[w*WORD_W +: WORD_W];
    assign pv = patValW[w*WORD_W +: WORD_W];
    assign pm = patMaskW[w*WORD_W +: WORD_W];
    assign trigWordOk[w]   = ~|((vSlice ^ tv) & tm);
    assign trigWordUsed[w] = |tm;
    assign patWordOk[w]    = ~|((vSlice ^ pv) & pm);
    assign patWordUsed[w]  = |pm;
  end

  assign trigHit = eligible && (&trigWordOk) && (|trigWordUsed);
  assign patHit  = eligible && (&patWordOk) && (|patWordUsed);

  always_ff @(posedge clk) begin
    if (rst) begin
      prevData <= '0;
      havePrev <= 1'b0;
    end else if (strobes.sampleEn) begin
      prevData <= dataIn;
      havePrev <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trigPulse  <= 1'b0;
      matchPulse <= 1'b0;
      trigTsReq  <= 1'b0;
      matchTsReq <= 1'b0;
    end else begin
      trigPulse  <= trigHit;
      matchPulse <= patHit;
      trigTsReq  <= trigHit && strobes.trigTsEn;
      matchTsReq <= patHit && strobes.patTsEn;
    end
  end

endmodule

// File: rtl/pm_trigger_unit.sv
module pm_trigger_unit
  import pm_trig_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              dataValid,
  output logic              trigPulse,
  output logic              matchPulse,
  output logic              trigTsReq,
  output logic              matchTsReq
);
  ctrlStrobes_t strobes;
  logic [DATA_W-1:0] trigValW, trigMaskW, patValW, patMaskW;

  pm_ctrl #(.DATA_W(DATA_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .dataValid(dataValid),
    .strobes(strobes), .trigValW(trigValW), .trigMaskW(trigMaskW),
    .patValW(patValW), .patMaskW(patMaskW)
  );

  pm_datapath #(.DATA_W(DATA_W), .WORD_W(WORD_W)) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes), .dataIn(dataIn),
    .trigValW(trigValW), .trigMaskW(trigMaskW), .patValW(patValW),
    .patMaskW(patMaskW), .trigPulse(trigPulse), .matchPulse(matchPulse),
    .trigTsReq(trigTsReq), .matchTsReq(matchTsReq)
  );

endmodule

// File: rtl/pm_trigger_unit_chk.sv
module pm_trigger_unit_chk #(
  parameter int DATA_W = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              dataValid,
  input logic              patTsEn,
  input logic              trigTsEn,
  input logic [DATA_W-1:0] trigMaskW,
  input logic [DATA_W-1:0] patMaskW,
  input logic              trigPulse,
  input logic              matchPulse,
  input logic              trigTsReq,
  input logic              matchTsReq
);
  // R1: outputs clear in the cycle after reset
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> !trigPulse && !matchPulse && !trigTsReq && !matchTsReq);

  // R7: a pulse only follows a valid sample
  a_r7_trig_after_valid: assert property (@(posedge clk) disable iff (rst)
    trigPulse |-> $past(dataValid));
  a_r7_match_after_valid: assert property (@(posedge clk) disable iff (rst)
    matchPulse |-> $past(dataValid));

  // R4: an all-zero mask never yields an event
  a_r4_trig_zero_mask: assert property (@(posedge clk) disable iff (rst)
    ($past(trigMaskW) == '0) |-> !trigPulse);
  a_r4_pat_zero_mask: assert property (@(posedge clk) disable iff (rst)
    ($past(patMaskW) == '0) |-> !matchPulse);

  // R8: pattern timestamp request tracks pulse and enable
  a_r8_match_ts_needs_pulse: assert property (@(posedge clk) disable iff (rst)
    matchTsReq |-> matchPulse && $past(patTsEn));
  a_r8_match_ts_when_enabled: assert property (@(posedge clk) disable iff (rst)
    matchPulse && $past(patTsEn) |-> matchTsReq);

  // R9: trigger timestamp request tracks pulse and enable
  a_r9_trig_ts_needs_pulse: assert property (@(posedge clk) disable iff (rst)
    trigTsReq |-> trigPulse && $past(trigTsEn));
  a_r9_trig_ts_when_enabled: assert property (@(posedge clk) disable iff (rst)
    trigPulse && $past(trigTsEn) |-> trigTsReq);

endmodule

bind pm_trigger_unit pm_trigger_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .dataValid(dataValid),
  .patTsEn(strobes.patTsEn), .trigTsEn(strobes.trigTsEn),
  .trigMaskW(trigMaskW), .patMaskW(patMaskW),
  .trigPulse(trigPulse), .matchPulse(matchPulse),
  .trigTsReq(trigTsReq), .matchTsReq(matchTsReq)
);

// File: tb/pm_trigger_unit_tb_top.sv
module pm_trigger_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;

  logic clk = 1'b0;
  logic rst;
  logic regWrEn;
  logic [5:0] regAddr;
  logic [31:0] regWrData, regRdData;
  logic [255:0] dataIn;
  logic dataValid;
  logic trigPulse, matchPulse, trigTsReq, matchTsReq;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string curReq = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_trigger_unit dut_i (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .dataIn(dataIn),
    .dataValid(dataValid), .trigPulse(trigPulse), .matchPulse(matchPulse),
    .trigTsReq(trigTsReq), .matchTsReq(matchTsReq)
  );

  // Behavioural reference: banks 0 trigVal, 1 trigMask, 2 patVal, 3 patMask
  logic [31:0] mBank [4][NW];
  logic [3:0] mCtrl;
  logic [255:0] mPrev;
  bit mHave;
  bit eT, eM, eTT, eMT;

  function automatic bit setHits(int valBank, logic [255:0] v);
    bit any = 0;
    bit ok = 1;
    for (int w = 0; w < NW; w++) begin
      logic [31:0] m = mBank[valBank+1][w];
      if (m != 0) any = 1;
      if (((v[w*32 +: 32] ^ mBank[valBank][w]) & m) != 0) ok = 0;
    end
    return any && ok;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 4; b++) for (int w = 0; w < NW; w++) mBank[b][w] = '0;
      mCtrl = '0; mPrev = '0; mHave = 0;
      eT = 0; eM = 0; eTT = 0; eMT = 0;
    end else begin
      logic [255:0] cmp;
      bit elig, t, m;
      cmp = mCtrl[0] ? (dataIn ^ mPrev) : dataIn;
      elig = dataValid && (!mCtrl[0] || mHave);
      t = elig && setHits(0, cmp);
      m = elig && setHits(2, cmp);
      eT = t; eM = m; eTT = t && mCtrl[2]; eMT = m && mCtrl[1];
      if (dataValid) begin mPrev = dataIn; mHave = 1; end
      if (regWrEn) begin
        if (regAddr < 32) mBank[regAddr/8][regAddr%8] = regWrData;
        else if (regAddr == 32) mCtrl = regWrData[3:0];
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Compare all outputs on every clock, away from the edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(curReq, "trigPulse", 32'(trigPulse), 32'(eT));
      chk(curReq, "matchPulse", 32'(matchPulse), 32'(eM));
      chk("R9", "trigTsReq", 32'(trigTsReq), 32'(eTT));
      chk("R8", "matchTsReq", 32'(matchTsReq), 32'(eMT));
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = 6'(a); regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rdChk(string req, int a, logic [31:0] exp);
    @(negedge clk);
    regAddr = 6'(a);
    #1;
    chk(req, $sformatf("read addr %0d", a), regRdData, exp);
  endtask

  task automatic smp(logic [255:0] d, logic v);
    @(negedge clk);
    dataIn = d; dataValid = v;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) smp(dataIn, 1'b0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1; dataValid = 0; regWrEn = 0;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int w = 0; w < NW; w++) r[w*32 +: 32] = $urandom;
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [255:0] d, x;
    rst = 1; regWrEn = 0; regAddr = 0; regWrData = 0; dataIn = '0; dataValid = 0;
    repeat (3) @(negedge clk);
    chk("R1", "trigPulse in reset", 32'(trigPulse), 0);
    chk("R1", "matchTsReq in reset", 32'(matchTsReq), 0);
    rst = 0;
    // R1: every register reads zero after reset
    for (int a = 0; a < 34; a++) rdChk("R1", a, 0);

    // R2: readback of all four banks
    curReq = "R2";
    for (int a = 0; a < 32; a++) wr(a, 32'hA5000000 | 32'(a * 32'h01010101));
    for (int a = 0; a < 32; a++) rdChk("R2", a, 32'hA5000000 | 32'(a * 32'h01010101));
    // R3: control bits and unused addresses
    wr(32, 32'hFFFFFFF0);
    rdChk("R3", 32, 0);
    wr(40, 32'h12345678);
    rdChk("R3", 40, 0);
    for (int a = 0; a < 32; a++) wr(a, 0);

    // R4: all-zero masks never match, whatever the data
    curReq = "R4";
    smp('0, 1); smp(rnd256(), 1); smp('1, 1);
    idle(2);

    // R5: value matching, trigger on word3 low half, pattern on words 0 and 7
    curReq = "R5";
    wr(8 + 3, 32'h0000FFFF); wr(3, 32'h00001234);
    wr(24 + 0, 32'hFF000000); wr(16 + 0, 32'hAB000000);
    wr(24 + 7, 32'h00000001); wr(16 + 7, 32'h00000001);
    d = rnd256(); d[3*32 +: 16] = 16'h1234; d[7:0] = 8'h00; d[255] = 1'b0;
    smp(d, 1);
    d[3*32] = ~d[3*32];
    smp(d, 1);
    d = rnd256(); d[31:24] = 8'hAB; d[224] = 1'b1; d[3*32 +: 16] = 16'h0000;
    smp(d, 1);
    idle(2);

    // Both events on one sample, both timestamp enables set (R8, R9)
    curReq = "R7";
    wr(32, 32'h6);
    d = rnd256(); d[3*32 +: 16] = 16'h1234; d[31:24] = 8'hAB; d[224] = 1'b1;
    smp(d, 1);
    smp(d, 0);          // valid low: no pulse (R7)
    smp(d, 1);
    // write landing with a sample: old config applies to this sample (R2)
    @(negedge clk);
    regWrEn = 1; regAddr = 6'(8 + 3); regWrData = 32'h0; dataIn = d; dataValid = 1;
    @(negedge clk);
    regWrEn = 0; dataValid = 1;
    idle(2);
    wr(8 + 3, 32'h0000FFFF);

    // R10: trigger type bit has no effect on outputs
    curReq = "R10";
    wr(32, 32'hE);
    rdChk("R10", 32, 32'hE);
    smp(d, 1); smp(d ^ 256'h1, 1); smp(d, 1);
    idle(2);

    // R6: toggle mode, first valid sample after reset never hits
    curReq = "R6";
    doReset();
    x = '0; x[3*32 +: 16] = 16'h1234;
    wr(8 + 3, 32'h0000FFFF); wr(3, 32'h00001234);
    wr(32, 32'h5);
    smp(x, 1);          // toggle vector vs zero would match, but no prior sample
    smp(x, 0);
    smp(x ^ x, 1);      // toggle = x -> trigger
    smp(x ^ x, 1);      // toggle = 0 -> none
    smp(x, 0);          // invalid sample does not update previous
    smp(x, 1);          // toggle = x -> trigger
    idle(2);

    // Random traffic in both modes
    curReq = "R5";
    wr(32, 32'h6);
    for (int i = 0; i < 60; i++) begin
      d = rnd256();
      if (i % 3 == 0) d[3*32 +: 16] = 16'h1234;
      smp(d, 1'($urandom % 4 != 0));
    end
    curReq = "R6";
    wr(32, 32'h7);
    for (int i = 0; i < 60; i++) begin
      d = dataIn;
      if (i % 2 == 0) d = d ^ x; else d[0] = ~d[0];
      smp(d, 1'($urandom % 5 != 0));
    end
    idle(3);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule